// File: doc/BRIEF.md
# Indexed Configuration Register Port

This block holds a small set of byte-wide configuration registers behind an index/data pair of host locations. The host first writes a register number to the index location (offset 0). Later reads or writes at the data location (offset 4) reach the register that number selects. The index stays in place until the host writes a new one, so several data accesses can follow a single index write.

The register set has these entries:
- a configuration byte whose revision field and base-location flag are read-only;
- a control byte holding the secondary-channel enable, two prefetch disables and a fast device-select field;
- seven drive timing bytes, where the sixth byte also carries two prefetch disables;
- a prefetch burst-size byte;
- a scratch byte that software uses to probe for the block.

The decoded control fields and the raw timing bytes leave the block as plain outputs for the drive-side logic.

A two-state machine answers reads. In `ST_IDLE` the block waits. When a read strobe arrives at the index or data location without a write strobe, the `GO_RESP` transition captures the byte and enters `ST_RESP`. In `ST_RESP` the captured byte is presented for exactly one cycle with the valid flag high. From there the `STAY_RESP` transition applies when another read arrives at once, and the `BACK_IDLE` transition applies otherwise.

Top module: `cfgp_index_port`

## Requirements
- R1: A write at offset 0 latches `host_wdata` as the index, and the index resets to 0x00. A read at offset 0 returns the current index with `host_rvalid` high on the cycle after the strobe.
- R2: A write at offset 4 updates the register that the index selects, and the new value is visible on the outputs after that clock edge. A read at offset 4 returns that register's value one cycle after the strobe.
- R3: Register 0x50 reads bits [1:0] as the revision parameter (nonzero, default 2) and bit 5 as the alternate-base parameter (default 1). Writes do not change these bits. Bits 7, 6, 4, 3 and 2 are writable and reset to 0.
- R4: In register 0x51, bit 3 drives `sec_chan_en`, bit 6 drives `pf_disable[0]` and bit 7 drives `pf_disable[1]`. Bit 4 is plain storage.
- R5: In register 0x57, bit 2 drives `pf_disable[2]` and bit 3 drives `pf_disable[3]`. Registers 0x52 to 0x58 appear on `drive_timing`, with byte k equal to register 0x52+k.
- R6: In register 0x51, the bits of mask 0x27 form a single fast device-select field. It becomes set only when a written byte has all four bits set; otherwise it clears. It reads back as 0x27 or 0x00 and drives `fast_devsel`.
- R7: Register 0x59 holds the burst size, resets to 0x40, is writable and drives `burst_cfg`.
- R8: Register 0x5B is a scratch byte that reads back the last value written to it, and it resets to 0x00.
- R9: An index outside 0x50 to 0x59 and 0x5B reads as 0xFF. A write to such an index changes no register and no output.
- R10: After reset, registers 0x51 to 0x58 read 0x00, so all outputs other than `burst_cfg` are zero.
- R11: When the write and read strobes are high in the same cycle, only the write takes effect and no read response follows. A strobe at any offset other than 0 or 4 gets no response and changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | ADDR_W (3) | Host location offset; 0 is the index, 4 is the data |
| host_wr | input | 1 | Write strobe |
| host_rd | input | 1 | Read strobe |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data, valid when `host_rvalid` is high |
| host_rvalid | output | 1 | Read response valid, one cycle after the strobe |
| sec_chan_en | output | 1 | Secondary channel enable |
| pf_disable | output | 4 | Per-drive prefetch disable, bit n for drive n |
| fast_devsel | output | 1 | Fast device-select timing |
| burst_cfg | output | 8 | Prefetch burst-size setting |
| drive_timing | output | 56 | Timing registers 0x52..0x58, byte k = register 0x52+k |

## Verification
Read data and `host_rvalid` are due exactly one clock edge after the cycle that carries the read strobe. Write effects on the exported fields are due at the same edge that samples the write strobe. The bench drives each strobe from one falling edge to the next. A monitor pops the queued expected byte at the falling edge that follows the capturing rising edge, and it flags any response that arrives when nothing is queued. Output fields are compared at the falling edge right after the write has been taken, so every comparison lands half a cycle after the edge that should have produced the result.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } bus_st_t;

    localparam logic [7:0] IX_CFG     = 8'h50;
    localparam logic [7:0] IX_CTL     = 8'h51;
    localparam logic [7:0] IX_TIM_LO  = 8'h52;
    localparam logic [7:0] IX_PF23    = 8'h57;
    localparam logic [7:0] IX_TIM_HI  = 8'h58;
    localparam logic [7:0] IX_BURST   = 8'h59;
    localparam logic [7:0] IX_SCRATCH = 8'h5B;

    localparam int NUM_TIM = int'(IX_TIM_HI) - int'(IX_TIM_LO) + 1;
    localparam int TIM_W   = $clog2(NUM_TIM);
    localparam int PF_SLOT = int'(IX_PF23) - int'(IX_TIM_LO);

    localparam logic [7:0] FAST_MASK  = 8'h27;
    localparam logic [7:0] BURST_DFLT = 8'h40;
    localparam logic [7:0] NO_REG     = 8'hFF;

endpackage

// File: rtl/cfgp_bus_fsm.sv
module cfgp_bus_fsm
    import cfgp_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter logic [ADDR_W-1:0] INDEX_OFS = '0,
    parameter logic [ADDR_W-1:0] DATA_OFS  = ADDR_W'(4)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [7:0]        wdata,
    input  logic [7:0]        rf_rdata,
    output logic [7:0]        idx,
    output logic              rf_we,
    output logic              rd_valid,
    output logic [7:0]        rdata
);

    bus_st_t    state_q, state_d;
    logic [7:0] idx_q;
    logic [7:0] rdata_q;
    logic       at_index, at_data, wr_index, rd_take;

    assign at_index = (addr == INDEX_OFS);
    assign at_data  = (addr == DATA_OFS);
    assign wr_index = wr_en && at_index;
    assign rf_we    = wr_en && at_data;
    assign rd_take  = rd_en && !wr_en && (at_index || at_data);

    // next-state selection: GO_RESP, STAY_RESP, BACK_IDLE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (rd_take) state_d = ST_RESP;
            ST_RESP: state_d = rd_take ? ST_RESP : ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // index and read capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q   <= 8'h00;
            rdata_q <= 8'h00;
        end else begin
            if (wr_index) idx_q <= wdata;
            if (rd_take)  rdata_q <= at_index ? idx_q : rf_rdata;
        end
    end

    // outputs
    always_comb begin
        idx      = idx_q;
        rdata    = rdata_q;
        rd_valid = (state_q == ST_RESP);
    end

    assert_index_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_index |=> $stable(idx_q));

    assert_index_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
        wr_index |=> (idx_q == $past(wdata)));

    assert_resp_due_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en && at_data) |=> rd_valid);

    assert_no_resp_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_en || wr_en) |=> !rd_valid);

endmodule

// File: rtl/cfgp_regfile.sv
module cfgp_regfile
    import cfgp_pkg::*;
#(
    parameter logic [1:0] REV      = 2'd2,
    parameter bit         ALT_BASE = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we,
    input  logic [7:0]           idx,
    input  logic [7:0]           wdata,
    output logic [7:0]           rdata,
    output logic                 sec_en,
    output logic [3:0]           pf_dis,
    output logic                 fast_devsel,
    output logic [7:0]           burst_len,
    output logic [NUM_TIM*8-1:0] tim_flat
);

    logic [1:0] cfg_hi;
    logic [2:0] cfg_mid;
    logic [1:0] ctl_hi;
    logic [1:0] ctl_mid;
    logic       fast_q;
    logic [7:0] burst_q;
    logic [7:0] scratch_q;
    logic [7:0] tim_q [NUM_TIM];

    logic [7:0]       tim_off;
    logic [TIM_W-1:0] tim_sel;
    logic             in_tim;

    assign tim_off = idx - IX_TIM_LO;
    assign tim_sel = tim_off[TIM_W-1:0];
    assign in_tim  = (idx >= IX_TIM_LO) && (idx <= IX_TIM_HI);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_hi    <= '0;
            cfg_mid   <= '0;
            ctl_hi    <= '0;
            ctl_mid   <= '0;
            fast_q    <= 1'b0;
            burst_q   <= BURST_DFLT;
            scratch_q <= 8'h00;
        end else if (we) begin
            if (idx == IX_CFG) begin
                cfg_hi  <= wdata[7:6];
                cfg_mid <= wdata[4:2];
            end
            if (idx == IX_CTL) begin
                ctl_hi  <= wdata[7:6];
                ctl_mid <= wdata[4:3];
                fast_q  <= ((wdata & FAST_MASK) == FAST_MASK);
            end
            if (idx == IX_BURST)   burst_q   <= wdata;
            if (idx == IX_SCRATCH) scratch_q <= wdata;
        end
    end

    for (genvar k = 0; k < NUM_TIM; k++) begin : g_tim
        always_ff @(posedge clk) begin
            if (!rst_n)
                tim_q[k] <= 8'h00;
            else if (we && in_tim && (tim_sel == TIM_W'(k)))
                tim_q[k] <= wdata;
        end
        assign tim_flat[k*8 +: 8] = tim_q[k];
    end

    always_comb begin
        rdata = NO_REG;
        if (idx == IX_CFG)
            rdata = {cfg_hi, ALT_BASE, cfg_mid, REV};
        else if (idx == IX_CTL)
            rdata = {ctl_hi, fast_q, ctl_mid, {3{fast_q}}};
        else if (in_tim)
            rdata = tim_q[tim_sel];
        else if (idx == IX_BURST)
            rdata = burst_q;
        else if (idx == IX_SCRATCH)
            rdata = scratch_q;
    end

    assign sec_en      = ctl_mid[0];
    assign pf_dis      = {tim_q[PF_SLOT][3], tim_q[PF_SLOT][2], ctl_hi[1], ctl_hi[0]};
    assign fast_devsel = fast_q;
    assign burst_len   = burst_q;

    logic impl_idx;
    assign impl_idx = (idx == IX_CFG) || (idx == IX_CTL) || in_tim ||
                      (idx == IX_BURST) || (idx == IX_SCRATCH);

    assert_scratch_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (we && idx == IX_SCRATCH) |=> (scratch_q == $past(wdata)));

    assert_unimpl_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !impl_idx) |=> ($stable(tim_flat) && $stable(burst_len) &&
                               $stable(pf_dis) && $stable(sec_en) && $stable(fast_devsel)));

    assert_pf_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(pf_dis));

    assert_fast_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(we && idx == IX_CTL) |=> $stable(fast_devsel));

endmodule

// File: rtl/cfgp_index_port.sv
module cfgp_index_port
    import cfgp_pkg::*;
#(
    parameter int         ADDR_W   = 3,
    parameter logic [1:0] REV      = 2'd2,
    parameter bit         ALT_BASE = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    host_addr,
    input  logic                 host_wr,
    input  logic                 host_rd,
    input  logic [7:0]           host_wdata,
    output logic [7:0]           host_rdata,
    output logic                 host_rvalid,
    output logic                 sec_chan_en,
    output logic [3:0]           pf_disable,
    output logic                 fast_devsel,
    output logic [7:0]           burst_cfg,
    output logic [NUM_TIM*8-1:0] drive_timing
);

    logic [7:0] idx;
    logic [7:0] rf_rdata;
    logic       rf_we;

    cfgp_bus_fsm #(
        .ADDR_W    (ADDR_W),
        .INDEX_OFS ('0),
        .DATA_OFS  (ADDR_W'(4))
    ) u_bus (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr     (host_addr),
        .wr_en    (host_wr),
        .rd_en    (host_rd),
        .wdata    (host_wdata),
        .rf_rdata (rf_rdata),
        .idx      (idx),
        .rf_we    (rf_we),
        .rd_valid (host_rvalid),
        .rdata    (host_rdata)
    );

    cfgp_regfile #(
        .REV      (REV),
        .ALT_BASE (ALT_BASE)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .we          (rf_we),
        .idx         (idx),
        .wdata       (host_wdata),
        .rdata       (rf_rdata),
        .sec_en      (sec_chan_en),
        .pf_dis      (pf_disable),
        .fast_devsel (fast_devsel),
        .burst_len   (burst_cfg),
        .tim_flat    (drive_timing)
    );

endmodule

// File: tb/cfgp_index_port_tb.sv
module cfgp_index_port_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  host_addr = '0;
    logic        host_wr = 1'b0;
    logic        host_rd = 1'b0;
    logic [7:0]  host_wdata = '0;
    logic [7:0]  host_rdata;
    logic        host_rvalid;
    logic        sec_chan_en;
    logic [3:0]  pf_disable;
    logic        fast_devsel;
    logic [7:0]  burst_cfg;
    logic [55:0] drive_timing;

    int checks = 0;
    int errors = 0;
    logic [7:0] exp_q [$];
    string      tag_q [$];

    always #10 clk = ~clk;

    cfgp_index_port u_dut (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
        .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .host_rvalid(host_rvalid), .sec_chan_en(sec_chan_en), .pf_disable(pf_disable),
        .fast_devsel(fast_devsel), .burst_cfg(burst_cfg), .drive_timing(drive_timing)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // monitor: compares read responses against the scoreboard
    always @(negedge clk) begin
        if (rst_n && host_rvalid) begin
            if (exp_q.size() == 0) begin
                checks++;
                errors++;
                $display("FAIL R11 unexpected response actual=%0h expected=none", host_rdata);
            end else begin
                automatic logic [7:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                check(t, 64'(host_rdata), 64'(e));
            end
        end
    end

    task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] a, input logic [7:0] e, input string t);
        @(negedge clk);
        host_addr = a; host_rd = 1'b1;
        if (a == 3'd0 || a == 3'd4) begin
            exp_q.push_back(e);
            tag_q.push_back(t);
        end
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic reg_write(input logic [7:0] ix, input logic [7:0] d);
        bus_write(3'd0, ix);
        bus_write(3'd4, d);
    endtask

    task automatic reg_read(input logic [7:0] ix, input logic [7:0] e, input string t);
        bus_write(3'd0, ix);
        bus_read(3'd4, e, t);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R10 reset state
        check("R10 exports", {sec_chan_en, pf_disable, fast_devsel}, 64'h0);
        check("R10 timing", 64'(drive_timing), 64'h0);
        check("R7 burst reset", 64'(burst_cfg), 64'h40);
        bus_read(3'd0, 8'h00, "R1 index reset");
        reg_read(8'h51, 8'h00, "R10 ctl reset");
        reg_read(8'h5B, 8'h00, "R8 scratch reset");

        // R1 index latch and readback
        bus_write(3'd0, 8'h57);
        bus_read(3'd0, 8'h57, "R1 index readback");

        // R3 config byte
        reg_read(8'h50, 8'h22, "R3 cfg reset");
        reg_write(8'h50, 8'hFF);
        reg_read(8'h50, 8'hFE, "R3 cfg all ones");
        reg_write(8'h50, 8'h00);
        reg_read(8'h50, 8'h22, "R3 cfg ro bits");

        // R4 control fields
        reg_write(8'h51, 8'hC8);
        check("R4 sec_en", 64'(sec_chan_en), 64'h1);
        check("R4 pf01", 64'(pf_disable), 64'h3);
        check("R6 fast off", 64'(fast_devsel), 64'h0);
        bus_read(3'd4, 8'hC8, "R4 ctl readback");

        // R6 fast field
        bus_write(3'd4, 8'h37);
        check("R6 fast on", 64'(fast_devsel), 64'h1);
        check("R4 sec_en cleared", 64'(sec_chan_en), 64'h0);
        bus_read(3'd4, 8'h37, "R6 ctl readback full");
        bus_write(3'd4, 8'h21);
        check("R6 partial clears", 64'(fast_devsel), 64'h0);
        bus_read(3'd4, 8'h00, "R6 partial readback");

        // R5 timing and drive 2/3 prefetch
        reg_write(8'h57, 8'h0C);
        check("R5 pf23", 64'(pf_disable), 64'hC);
        reg_write(8'h52, 8'hA5);
        reg_write(8'h58, 8'h3C);
        check("R5 timing map", 64'(drive_timing), 64'h3C0C_0000_0000_A5);
        reg_read(8'h58, 8'h3C, "R2 timing readback");
        reg_write(8'h57, 8'h04);
        check("R5 pf2 only", 64'(pf_disable), 64'h4);

        // R7 burst
        reg_write(8'h59, 8'h80);
        check("R7 burst write", 64'(burst_cfg), 64'h80);
        reg_read(8'h59, 8'h80, "R7 burst readback");

        // R8 scratch
        reg_write(8'h5B, 8'hBD);
        reg_read(8'h5B, 8'hBD, "R8 scratch readback");
        reg_write(8'h5B, 8'h00);
        reg_read(8'h5B, 8'h00, "R8 scratch cleared");

        // R9 unimplemented indices
        reg_write(8'h5A, 8'h55);
        reg_read(8'h5A, 8'hFF, "R9 read 5A");
        reg_write(8'h4F, 8'hFF);
        reg_read(8'h4F, 8'hFF, "R9 read 4F");
        reg_write(8'h00, 8'hFF);
        check("R9 exports untouched", {sec_chan_en, pf_disable, fast_devsel, burst_cfg},
              {1'b0, 4'h4, 1'b0, 8'h80});
        check("R9 timing untouched", 64'(drive_timing), 64'h3C04_0000_0000_A5);

        // R11 simultaneous strobes and stray offsets
        bus_write(3'd0, 8'h5B);
        @(negedge clk);
        host_addr = 3'd4; host_wdata = 8'h99; host_wr = 1'b1; host_rd = 1'b1;
        @(negedge clk);
        host_wr = 1'b0; host_rd = 1'b0;
        check("R11 no response on write+read", 64'(host_rvalid), 64'h0);
        bus_read(3'd4, 8'h99, "R11 write took effect");
        bus_write(3'd2, 8'h51);
        bus_read(3'd2, 8'h00, "R11 stray read");
        check("R11 stray read no response", 64'(host_rvalid), 64'h0);
        bus_read(3'd0, 8'h5B, "R11 stray write ignored");

        repeat (3) @(negedge clk);
        check("R2 scoreboard drained", 64'(exp_q.size()), 64'h0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule